// File: doc/BRIEF.md
# HALT Wake-Up Sequencer

This block decides when a small microcontroller core may leave its low-power HALT state, and how it continues afterwards. The core asks to halt with `halt_req`. At that moment the block stores a snapshot of the 8-bit wake port and of the interrupt request lines. While halted it watches for a change on any port pin whose wake option is set, and for any interrupt request that was not already raised when the halt began.

Once a wake event is seen, the block holds the core halted for a fixed settling window of `SETTLE_CYC` clock cycles, so that the oscillator can become stable. When the window closes, it gives the core one of two one-cycle strobes. `resume_next` tells the core to carry on with the next instruction. `irq_take` tells it to enter the interrupt service routine. The second strobe comes only when a waking interrupt is enabled and the stack has room, and it comes one cycle later than the first would. The core pipeline, the vector logic and the oscillator are outside this block.

Top module: `halt_wake_seq`

## Requirements
- R1: After a synchronous active-high `rst`, the outputs are `halted`=0, `resume_next`=0 and `irq_take`=0, and the settling counter is idle.
- R2: A `halt_req` seen at a clock edge while running drives `halted` to 1 from that edge on. `halted` then stays 1 for as long as no wake event occurs.
- R3: A pin of `port_in` can wake the block only when its bit in `port_wake_en` is 1, and only when it differs from the value sampled on the halt-entry edge. A pin whose enable bit is 0 has no effect.
- R4: A wake caused only by the port always ends with `resume_next` and never with `irq_take`.
- R5: An interrupt wake where every waking line has its `irq_en` bit at 0 ends with `resume_next`.
- R6: An interrupt wake where an enabled line wakes but `stack_full` is 1 on the wake edge ends with `resume_next`.
- R7: An interrupt wake where an enabled line wakes and `stack_full` is 0 on the wake edge ends with `irq_take`.
- R8: A line of `irq_req` that is already 1 on the halt-entry edge cannot wake the block for the whole of that halt. It is also never counted as a waking line.
- R9: After a wake event at edge E, `halted` stays 1 through edge E+SETTLE_CYC-1. On the resume path, `resume_next` is 1 and `halted` is 0 in the cycle after edge E+SETTLE_CYC.
- R10: On the interrupt path, `halted` stays 1 and no strobe is given in the cycle after edge E+SETTLE_CYC. `irq_take` is 1 and `halted` is 0 in the cycle after edge E+SETTLE_CYC+1.
- R11: A `halt_req` that arrives while the settling window or the interrupt gap cycle is running is ignored. It does not change the exit timing, and the block is running afterwards.
- R12: Each strobe lasts exactly one cycle, and `resume_next` and `irq_take` are never 1 together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| halt_req | input | 1 | Request from the core to enter HALT |
| port_in | input | PORT_W | Wake port pin levels |
| port_wake_en | input | PORT_W | Wake option, one bit per port pin |
| irq_req | input | IRQ_N | Interrupt request flags |
| irq_en | input | IRQ_N | Interrupt enable bits |
| stack_full | input | 1 | Return stack has no free entry |
| halted | output | 1 | 1 while halted, settling or in the interrupt gap |
| resume_next | output | 1 | One-cycle strobe: continue at the next instruction |
| irq_take | output | 1 | One-cycle strobe: start interrupt service |

## Verification
The bench changes every input on the falling edge, so the rising edge that follows is the wake edge E. After that it counts falling edges. After SETTLE_CYC of them it expects `halted` high and no strobe. One falling edge later it expects either `resume_next` with `halted` low, or the idle gap cycle. On the interrupt path it expects `irq_take` one falling edge after the gap, and the strobe must be gone on the next falling edge. For the cases where nothing must happen (disabled pins, flags that were pending at entry, a halt request during settling), the bench holds the stimulus for tens of cycles and checks that `halted` is still 1 and that no strobe has appeared.

// File: rtl/hws_pkg.sv
package hws_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_HALT   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_GAP    = 2'd3
  } hws_state_t;
endpackage

// File: rtl/hws_wake_detect.sv
module hws_wake_detect #(
  parameter int PORT_W = 8,
  parameter int IRQ_N  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [PORT_W-1:0] port_in,
  input  logic [PORT_W-1:0] port_wake_en,
  input  logic [IRQ_N-1:0]  irq_req,
  input  logic [IRQ_N-1:0]  irq_en,
  input  logic              stack_full,
  output logic              port_hit,
  output logic              irq_hit,
  output logic              irq_serviceable
);
  logic [PORT_W-1:0] port_snap_q;
  logic [IRQ_N-1:0]  irq_pend_q;
  logic [PORT_W-1:0] pin_hit;
  logic [IRQ_N-1:0]  fresh_irq;

  // a request line counts only if it was clear at halt entry
  function automatic logic [IRQ_N-1:0] fresh_lines(input logic [IRQ_N-1:0] req,
                                                   input logic [IRQ_N-1:0] pend);
    return req & ~pend;
  endfunction

  function automatic logic pin_changed(input logic now_v, input logic snap_v,
                                       input logic en_v);
    return en_v & (now_v ^ snap_v);
  endfunction

  always_ff @(posedge clk) begin
    if (rst) begin
      port_snap_q <= '0;
      irq_pend_q  <= '0;
    end else if (capture) begin
      port_snap_q <= port_in;
      irq_pend_q  <= irq_req;
    end
  end

  for (genvar i = 0; i < PORT_W; i++) begin : g_pin
    assign pin_hit[i] = pin_changed(port_in[i], port_snap_q[i], port_wake_en[i]);
  end

  assign fresh_irq       = fresh_lines(irq_req, irq_pend_q);
  assign port_hit        = |pin_hit;
  assign irq_hit         = |fresh_irq;
  assign irq_serviceable = (|(fresh_irq & irq_en)) & ~stack_full;
endmodule

// File: rtl/hws_settle_timer.sv
module hws_settle_timer #(
  parameter int SETTLE_CYC = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic done
);
  localparam int CW = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;
  localparam logic [CW-1:0] LAST = CW'(SETTLE_CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      busy_q <= 1'b0;
    end else if (start && !busy_q) begin
      cnt_q  <= '0;
      busy_q <= 1'b1;
    end else if (busy_q) begin
      if (cnt_q == LAST) begin
        busy_q <= 1'b0;
        cnt_q  <= '0;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  assign busy = busy_q;
  assign done = busy_q && (cnt_q == LAST);
endmodule

// File: rtl/hws_ctrl.sv
module hws_ctrl
  import hws_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic halt_req,
  input  logic wake_ev,
  input  logic take_irq_now,
  input  logic settle_done,
  output logic capture,
  output logic settle_start,
  output logic in_halt,
  output logic in_gap,
  output logic halted,
  output logic resume_next,
  output logic irq_take
);
  hws_state_t state_q;
  logic       take_q;

  assign capture      = (state_q == ST_RUN) && halt_req;
  assign settle_start = (state_q == ST_HALT) && wake_ev;
  assign in_halt      = (state_q == ST_HALT);
  assign in_gap       = (state_q == ST_GAP);
  assign halted       = (state_q != ST_RUN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_RUN;
      take_q      <= 1'b0;
      resume_next <= 1'b0;
      irq_take    <= 1'b0;
    end else begin
      resume_next <= 1'b0;
      irq_take    <= 1'b0;
      unique case (state_q)
        ST_RUN: if (halt_req) state_q <= ST_HALT;
        ST_HALT: if (wake_ev) begin
          take_q  <= take_irq_now;
          state_q <= ST_SETTLE;
        end
        ST_SETTLE: if (settle_done) begin
          if (take_q) begin
            state_q <= ST_GAP;
          end else begin
            state_q     <= ST_RUN;
            resume_next <= 1'b1;
          end
        end
        ST_GAP: begin
          state_q  <= ST_RUN;
          irq_take <= 1'b1;
        end
        default: state_q <= ST_RUN;
      endcase
    end
  end
endmodule

// File: rtl/halt_wake_seq.sv
module halt_wake_seq #(
  parameter int PORT_W     = 8,
  parameter int IRQ_N      = 4,
  parameter int SETTLE_CYC = 1024
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              halt_req,
  input  logic [PORT_W-1:0] port_in,
  input  logic [PORT_W-1:0] port_wake_en,
  input  logic [IRQ_N-1:0]  irq_req,
  input  logic [IRQ_N-1:0]  irq_en,
  input  logic              stack_full,
  output logic              halted,
  output logic              resume_next,
  output logic              irq_take
);
  logic capture, settle_start, settle_busy, settle_done;
  logic port_hit, irq_hit, irq_serviceable, wake_ev;
  logic in_halt, in_gap;

  hws_wake_detect #(.PORT_W(PORT_W), .IRQ_N(IRQ_N)) u_detect (
    .clk(clk), .rst(rst), .capture(capture),
    .port_in(port_in), .port_wake_en(port_wake_en),
    .irq_req(irq_req), .irq_en(irq_en), .stack_full(stack_full),
    .port_hit(port_hit), .irq_hit(irq_hit), .irq_serviceable(irq_serviceable)
  );

  assign wake_ev = port_hit | irq_hit;

  hws_settle_timer #(.SETTLE_CYC(SETTLE_CYC)) u_timer (
    .clk(clk), .rst(rst), .start(settle_start),
    .busy(settle_busy), .done(settle_done)
  );

  hws_ctrl u_ctrl (
    .clk(clk), .rst(rst), .halt_req(halt_req),
    .wake_ev(wake_ev), .take_irq_now(irq_serviceable),
    .settle_done(settle_done),
    .capture(capture), .settle_start(settle_start),
    .in_halt(in_halt), .in_gap(in_gap), .halted(halted),
    .resume_next(resume_next), .irq_take(irq_take)
  );
endmodule

// File: rtl/hws_checker.sv
module hws_checker #(
  parameter int SETTLE_CYC = 1024
) (
  input logic clk,
  input logic rst,
  input logic halt_req,
  input logic halted,
  input logic resume_next,
  input logic irq_take,
  input logic settle_busy,
  input logic settle_done,
  input logic wake_ev,
  input logic in_halt,
  input logic in_gap
);
  int unsigned busy_cnt;

  always_ff @(posedge clk) begin
    if (rst || !settle_busy) busy_cnt <= 0;
    else                     busy_cnt <= busy_cnt + 1;
  end

  // R1: reset leaves the block running with no strobe
  p_reset_idle_r1: assert property (@(posedge clk)
    rst |=> (!halted && !resume_next && !irq_take));

  // R2: without a wake event the halt holds
  p_halt_holds_r2: assert property (@(posedge clk) disable iff (rst)
    (in_halt && !wake_ev) |=> (halted && in_halt));

  // R9: the settling window is exactly SETTLE_CYC cycles long
  p_settle_len_r9: assert property (@(posedge clk) disable iff (rst)
    settle_done |-> (busy_cnt == SETTLE_CYC - 1));

  // R10: interrupt entry comes straight after the gap cycle
  p_take_after_gap_r10: assert property (@(posedge clk) disable iff (rst)
    in_gap |=> (irq_take && !halted));

  // R11: halt request while settling does not end the window early
  p_settle_ignores_halt_r11: assert property (@(posedge clk) disable iff (rst)
    (settle_busy && !settle_done && halt_req) |=> settle_busy);

  // R12: the strobes are exclusive, one cycle wide and given only while running
  p_strobe_excl_r12: assert property (@(posedge clk) disable iff (rst)
    !(resume_next && irq_take));
  p_strobe_once_r12: assert property (@(posedge clk) disable iff (rst)
    (resume_next || irq_take) |=> (!resume_next && !irq_take));
  p_strobe_running_r12: assert property (@(posedge clk) disable iff (rst)
    (resume_next || irq_take) |-> !halted);
endmodule

bind halt_wake_seq hws_checker #(.SETTLE_CYC(SETTLE_CYC)) u_chk (
  .clk(clk), .rst(rst), .halt_req(halt_req), .halted(halted),
  .resume_next(resume_next), .irq_take(irq_take),
  .settle_busy(settle_busy), .settle_done(settle_done),
  .wake_ev(wake_ev), .in_halt(in_halt), .in_gap(in_gap)
);

// File: tb/sim_halt_wake_seq.sv
`timescale 1ns/1ps
module sim_halt_wake_seq;
  localparam int PW = 8;
  localparam int IN = 4;
  localparam int N  = 1024;

  logic clk = 1'b0;
  logic rst;
  logic halt_req;
  logic [PW-1:0] port_in, port_wake_en;
  logic [IN-1:0] irq_req, irq_en;
  logic stack_full;
  logic halted, resume_next, irq_take;

  int n_run  = 0;
  int n_fail = 0;
  bit done_flag = 1'b0;

  always #10 clk = ~clk;

  halt_wake_seq #(.PORT_W(PW), .IRQ_N(IN), .SETTLE_CYC(N)) u0 (
    .clk(clk), .rst(rst), .halt_req(halt_req), .port_in(port_in),
    .port_wake_en(port_wake_en), .irq_req(irq_req), .irq_en(irq_en),
    .stack_full(stack_full), .halted(halted),
    .resume_next(resume_next), .irq_take(irq_take)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic int outs();
    return {29'd0, halted, resume_next, irq_take};
  endfunction

  task automatic enter_halt();
    halt_req = 1'b1;
    @(negedge clk);
    halt_req = 1'b0;
    chk(halted == 1'b1, "R2 halt entry", outs(), 4);
  endtask

  task automatic hold_check(input int cyc, input string req);
    for (int i = 0; i < cyc; i++) @(negedge clk);
    chk(outs() == 4, req, outs(), 4);
  endtask

  // stimulus was applied just before wake edge E
  task automatic expect_exit(input bit take, input string req);
    repeat (N) @(negedge clk);
    chk(outs() == 4, "R9 still settling at E+N-1", outs(), 4);
    @(negedge clk);
    if (!take) begin
      chk(outs() == 2, req, outs(), 2);
      @(negedge clk);
      chk(outs() == 0, "R12 resume strobe one cycle", outs(), 0);
    end else begin
      chk(outs() == 4, "R10 gap cycle", outs(), 4);
      @(negedge clk);
      chk(outs() == 1, req, outs(), 1);
      @(negedge clk);
      chk(outs() == 0, "R12 take strobe one cycle", outs(), 0);
    end
  endtask

  task automatic t_reset();
    rst = 1'b1; halt_req = 1'b0; port_in = 8'hA5; port_wake_en = '0;
    irq_req = '0; irq_en = '0; stack_full = 1'b0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(outs() == 0, "R1 reset state", outs(), 0);
  endtask

  task automatic t_port_wake();
    port_in = 8'hA5; port_wake_en = 8'h10; irq_en = 4'hF;
    enter_halt();
    port_in = 8'hA4;
    hold_check(30, "R3 disabled pin ignored");
    port_in = 8'hB4;
    expect_exit(1'b0, "R4 R9 port wake resumes");
  endtask

  task automatic t_irq_disabled();
    port_wake_en = '0; irq_en = 4'b1101; irq_req = '0;
    enter_halt();
    hold_check(10, "R2 no wake holds");
    irq_req = 4'b0010;
    expect_exit(1'b0, "R5 disabled irq resumes");
    irq_req = '0;
  endtask

  task automatic t_irq_stack_full();
    irq_en = 4'hF; stack_full = 1'b1;
    enter_halt();
    irq_req = 4'b0100;
    @(negedge clk);
    stack_full = 1'b0;
    repeat (N - 1) @(negedge clk);
    chk(outs() == 4, "R9 still settling", outs(), 4);
    @(negedge clk);
    chk(outs() == 2, "R6 stack full resumes", outs(), 2);
    @(negedge clk);
    irq_req = '0;
  endtask

  task automatic t_irq_take();
    irq_en = 4'b1000; stack_full = 1'b0;
    enter_halt();
    irq_req = 4'b1000;
    expect_exit(1'b1, "R7 R10 irq take");
    irq_req = '0;
  endtask

  task automatic t_pending();
    irq_en = 4'b0010; irq_req = 4'b0010; stack_full = 1'b0;
    enter_halt();
    hold_check(40, "R8 pending flag cannot wake");
    irq_req = 4'b0110;
    expect_exit(1'b0, "R8 pending line not serviced");
    irq_req = '0;
  endtask

  task automatic t_halt_in_settle();
    port_in = 8'h00; port_wake_en = 8'h01; irq_en = '0;
    enter_halt();
    port_in = 8'h01;
    repeat (100) @(negedge clk);
    halt_req = 1'b1;
    repeat (20) @(negedge clk);
    halt_req = 1'b0;
    repeat (N - 120) @(negedge clk);
    chk(outs() == 4, "R11 settle not shortened", outs(), 4);
    @(negedge clk);
    chk(outs() == 2, "R11 exit on time", outs(), 2);
    repeat (3) @(negedge clk);
    chk(outs() == 0, "R11 running afterwards", outs(), 0);
  endtask

  initial begin
    t_reset();
    t_port_wake();
    t_irq_disabled();
    t_irq_stack_full();
    t_irq_take();
    t_pending();
    t_halt_in_settle();
    if (!done_flag) begin
      done_flag = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done_flag) begin
      done_flag = 1'b1;
      n_run++;
      n_fail++;
      $display("FAIL watchdog: actual=%0d expected=%0d", 1, 0);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end
endmodule